// File: doc/BRIEF.md
# Periodic Real-Time Tick Interrupt Generator

This block produces a timeout at a fixed rate derived from a qualifying clock tick (`tick_en`, one cycle wide per E-clock tick). A free-running divider counts ticks. Its base divide is 2^`BASE_LOG2`, and a 2-bit rate select multiplies the period by 1, 2, 4 or 8. Each timeout sets a sticky status flag. When the interrupt enable is set, the flag also drives an interrupt request.

Software clears the flag by writing a status byte with the clear bit set. The divider does not depend on the flag or on the time of the clear. Each period is counted from the previous timeout, so service latency never shifts the timing. Only reset stops the divider or restarts it. There is no data stream in this block: every pin is a plain control or status signal, with no valid/ready handshake.

Top module: `rti_timer`

## Requirements
- R1: The period between timeouts is 2^(BASE_LOG2+s) `tick_en` cycles, where s is the active rate select value 0..3 (encodings 00, 01, 10, 11 give extra divide factors 1, 2, 4, 8).
- R2: After reset, the flag first rises at the clock edge that samples the 2^BASE_LOG2-th tick. This holds even if the rate select is written before that timeout.
- R3: Each period starts at the previous timeout. Clearing the flag at any point does not move the next timeout.
- R4: A rate select written mid-period takes effect at the next timeout boundary. The current period keeps its length.
- R5: Every timeout sets the flag. A timeout while the flag is already set leaves it set, and no events are counted, so one clear returns it to 0.
- R6: A write to `stat_we` with `stat_wdata` bit 6 = 1 clears the flag on that edge. A write with bit 6 = 0 leaves the flag unchanged.
- R7: If a timeout and a clearing write fall on the same edge, the flag ends up set.
- R8: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R9: Reset clears the flag, the rate select and the interrupt enable, and restarts the divider at zero. No other input restarts it.
- R10: The divider advances only on cycles where `tick_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Divider tick qualifier |
| cfg_we | input | 1 | Writes rate select and interrupt enable |
| cfg_rate | input | 2 | Rate select value to write |
| cfg_irq_en | input | 1 | Interrupt enable value to write |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data; bit 6 clears the flag |
| rate_q | output | 2 | Current rate select register |
| irq_en_q | output | 1 | Current interrupt enable register |
| flag_q | output | 1 | Timeout status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `BASE_LOG2` = 3, so the four rates give periods of 8, 16, 32 and 64 ticks. At that size the bench can measure every rate, observe a rate change taking effect at a boundary, and place a clear exactly on a timeout edge, all within a few hundred cycles. It also measures a run with a tick every other cycle, to show the divider counts only qualified cycles.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int RATE_W = 2;
  typedef logic [RATE_W-1:0] rate_t;
  typedef struct packed {
    rate_t rate;
    logic  irq_en;
  } rti_cfg_t;
endpackage

// File: rtl/rti_cfg_regs.sv
module rti_cfg_regs
  import rti_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  rate_t    rate_in,
  input  logic     irq_en_in,
  output rti_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.rate   <= rate_in;
      cfg.irq_en <= irq_en_in;
    end
  end

  // R9: the configuration changes only on a write
  p_cfg_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
endmodule

// File: rtl/rti_divider.sv
module rti_divider
  import rti_pkg::*;
#(
  parameter int BASE_LOG2 = 13
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  input  rate_t rate_sel,
  output logic  tmo
);
  localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  rate_t            rate_act;

  // the longest period wraps the shift to zero, so subtracting one gives all ones
  always_comb last = (ONE << (BASE_LOG2 + int'(rate_act))) - ONE;

  assign tmo = tick_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      rate_act <= '0;
    end else if (tick_en) begin
      if (tmo) begin
        cnt      <= '0;
        rate_act <= rate_sel;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  // R1: the count never passes the end of the active period
  p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
  // R4: the active rate changes only at a timeout boundary
  p_rate_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo |=> $stable(rate_act));
  // R10: no tick, no advance
  p_tick_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
endmodule

// File: rtl/rti_status.sv
module rti_status #(
  parameter int DATA_W  = 8,
  parameter int CLR_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_en,
  output logic              flag_q,
  output logic              irq_o
);
  logic clr;
  assign clr = we && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (tmo)   flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign irq_o = flag_q & irq_en;

  // R7: a timeout always leaves the flag set, even with a clear on the same edge
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> flag_q);
  // R6: a clearing write without a timeout drops the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[CLR_BIT] && !tmo) |=> !flag_q);
  // R6: a set flag survives anything but a clearing write
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(we && wdata[CLR_BIT])) |=> flag_q);
  // R5: the flag rises only on a timeout
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !tmo) |=> !flag_q);
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int DATA_W    = 8,
  parameter int CLR_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_irq_en,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] stat_wdata,
  output logic [1:0]        rate_q,
  output logic              irq_en_q,
  output logic              flag_q,
  output logic              irq_o
);
  rti_cfg_t cfg;
  logic     tmo;

  rti_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .rate_in   (cfg_rate),
    .irq_en_in (cfg_irq_en),
    .cfg       (cfg)
  );

  rti_divider #(.BASE_LOG2(BASE_LOG2)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .rate_sel (cfg.rate),
    .tmo      (tmo)
  );

  rti_status #(.DATA_W(DATA_W), .CLR_BIT(CLR_BIT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .tmo    (tmo),
    .we     (stat_we),
    .wdata  (stat_wdata),
    .irq_en (cfg.irq_en),
    .flag_q (flag_q),
    .irq_o  (irq_o)
  );

  assign rate_q   = cfg.rate;
  assign irq_en_q = cfg.irq_en;

  // R8: no request while the enable is low
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq_o);
endmodule

// File: tb/sim_rti_timer.sv
module sim_rti_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic cfg_irq_en = 1'b0;
  logic stat_we = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [1:0] rate_q;
  logic irq_en_q, flag_q, irq_o;
  logic sparse = 1'b0;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rti_timer #(.BASE_LOG2(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_we(cfg_we), .cfg_rate(cfg_rate), .cfg_irq_en(cfg_irq_en),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .rate_q(rate_q), .irq_en_q(irq_en_q), .flag_q(flag_q), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (sparse) tick_en = ~tick_en;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; stat_we = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  // called right after the flag was seen set; clears it and counts edges to the next set
  task automatic measure(input bit wr_cfg, input logic [1:0] rate, input logic ie,
                         output int n);
    stat_we = 1'b1; stat_wdata = 8'h40;
    cfg_we = wr_cfg; cfg_rate = rate; cfg_irq_en = ie;
    step();
    stat_we = 1'b0; cfg_we = 1'b0;
    n = 1;
    while (!flag_q && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic wait_flag();
    int k = 0;
    while (!flag_q && k < 1000) begin step(); k++; end
  endtask

  task automatic t_reset();
    do_reset();
    check(flag_q == 0, "R9 flag after reset", int'(flag_q), 0);
    check(irq_o == 0, "R9 irq after reset", int'(irq_o), 0);
    check(rate_q == 0, "R9 rate after reset", int'(rate_q), 0);
    check(irq_en_q == 0, "R9 enable after reset", int'(irq_en_q), 0);
  endtask

  task automatic t_first_period();
    int n;
    do_reset();
    cfg_we = 1; cfg_rate = 2'd3; cfg_irq_en = 0;
    step();
    cfg_we = 0;
    repeat (6) step();
    check(flag_q == 0, "R2 flag before first period end", int'(flag_q), 0);
    step();
    check(flag_q == 1, "R2 flag at first period end", int'(flag_q), 1);
    measure(1'b0, 2'd0, 1'b0, n);
    check(n == 64, "R1 period at rate 3", n, 64);
  endtask

  task automatic t_rates();
    int n;
    logic [1:0] seq [4] = '{2'd1, 2'd2, 2'd0, 2'd3};
    int prev = 64;
    wait_flag();
    for (int i = 0; i < 4; i++) begin
      measure(1'b1, seq[i], 1'b0, n);
      check(n == prev, "R4 old period kept after rate write", n, prev);
      measure(1'b0, 2'd0, 1'b0, n);
      check(n == (8 << seq[i]), "R1 new period", n, 8 << seq[i]);
      prev = 8 << seq[i];
    end
  endtask

  task automatic t_clear_timing();
    int n = 0;
    do_reset();
    wait_flag();
    repeat (3) begin step(); n++; end
    stat_we = 1; stat_wdata = 8'h40;
    step(); n++;
    stat_we = 0;
    check(flag_q == 0, "R3 flag cleared mid-period", int'(flag_q), 0);
    while (!flag_q && n < 1000) begin step(); n++; end
    check(n == 8, "R3 period from previous timeout", n, 8);
  endtask

  task automatic t_clear_bit();
    wait_flag();
    stat_we = 1; stat_wdata = 8'hBF;
    step();
    stat_we = 0;
    check(flag_q == 1, "R6 write with bit 6 low ignored", int'(flag_q), 1);
    stat_we = 1; stat_wdata = 8'h40;
    step();
    stat_we = 0;
    check(flag_q == 0, "R6 write with bit 6 high clears", int'(flag_q), 0);
  endtask

  task automatic t_sticky();
    do_reset();
    wait_flag();
    repeat (17) step();
    check(flag_q == 1, "R5 flag held over later timeouts", int'(flag_q), 1);
    stat_we = 1; stat_wdata = 8'h40;
    step();
    stat_we = 0;
    check(flag_q == 0, "R5 single clear after repeated timeouts", int'(flag_q), 0);
    step();
    check(flag_q == 0, "R5 no pending event after clear", int'(flag_q), 0);
  endtask

  task automatic t_collision();
    do_reset();
    wait_flag();
    stat_we = 1; stat_wdata = 8'h40;
    step();
    stat_we = 0;
    repeat (6) step();
    check(flag_q == 0, "R7 flag low before collision", int'(flag_q), 0);
    stat_we = 1; stat_wdata = 8'h40;
    step();
    stat_we = 0;
    check(flag_q == 1, "R7 set wins over clear", int'(flag_q), 1);
  endtask

  task automatic t_irq();
    wait_flag();
    check(irq_o == 0, "R8 masked request", int'(irq_o), 0);
    cfg_we = 1; cfg_rate = 2'd0; cfg_irq_en = 1;
    step();
    cfg_we = 0;
    check(irq_o == 1, "R8 enabled request", int'(irq_o), 1);
    stat_we = 1; stat_wdata = 8'h40;
    step();
    stat_we = 0;
    check(irq_o == 0, "R8 request drops with flag", int'(irq_o), 0);
  endtask

  task automatic t_sparse();
    int n;
    do_reset();
    wait_flag();
    tick_en = 1'b0;
    sparse = 1'b1;
    measure(1'b0, 2'd0, 1'b0, n);
    check(n == 16, "R10 period counts only ticks", n, 16);
    sparse = 1'b0;
    tick_en = 1'b1;
  endtask

  task automatic t_restart();
    do_reset();
    cfg_we = 1; cfg_rate = 2'd2; cfg_irq_en = 1;
    step();
    cfg_we = 0;
    repeat (4) step();
    do_reset();
    check(rate_q == 0 && irq_en_q == 0, "R9 config cleared by mid-period reset",
          int'({rate_q, irq_en_q}), 0);
    repeat (7) step();
    check(flag_q == 0, "R9 divider restarted", int'(flag_q), 0);
    step();
    check(flag_q == 1, "R9 full period after reset", int'(flag_q), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_period();
    t_rates();
    t_clear_timing();
    t_clear_bit();
    t_sticky();
    t_collision();
    t_irq();
    t_sparse();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule